// File: doc/BRIEF.md
# Odd-Byte Chaining Word Packer

This block turns a byte stream into 16-bit words for a list of scatter/gather move segments. A segment descriptor carries a 24-bit byte count and a flag that says whether more segments follow (chained) or the list ends here (final). Bytes are taken one at a time and paired into words. The earlier byte goes in the low lane and the later byte goes in the high lane.

A chained segment with an odd byte count does not pad its last byte. The byte is held as a residue and becomes the low lane of the word that the next segment's first byte completes. As a result, a list always yields as many words as its total byte count needs: two 5-byte segments give exactly five words. A final segment that leaves a lone byte sends it in one padded word and marks that word as carrying a single byte.

A synchronous flush input drops a held byte. A zero-count segment passes through without touching the residue. The words leave through a valid/ready register stage.

Top module: `odd_byte_packer`

## Requirements
- R1: In every output word, the byte that came earlier in stream order sits in bits [7:0] and the later byte sits in bits [15:8].
- R2: When a chained segment has an odd count, its last byte produces no word. Once the segment is done, `residue_valid` reads 1. A chained segment of count n emits floor(n/2) words when no byte was held at its start.
- R3: A held byte is the low lane of the word that the next non-empty segment's first byte completes.
- R4: When a final segment leaves a lone byte, exactly one word is sent with bits [15:8] equal to 0 and `out_single` equal to 1. Every other word has `out_single` equal to 0.
- R5: A list ending in a non-empty final segment emits ceil(N/2) words, where N is the number of bytes not discarded by flush. For example, 5+5 bytes give 5 words.
- R6: A zero-count segment of either kind is accepted, takes no bytes, and leaves `residue_valid` and the held byte unchanged.
- R7: A `flush` pulse makes `residue_valid` 0 on the next cycle. The discarded byte never appears in any later word.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_single` hold their values into the next cycle.
- R9: `seg_ready` is 1 only between segments, and `in_ready` is 0 whenever `seg_ready` is 1.
- R10: After reset, `out_valid` and `residue_valid` are 0, `seg_ready` is 1 and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | 1 | Segment descriptor offered |
| seg_ready | output | 1 | Descriptor taken this cycle (idle between segments) |
| seg_count | input | 24 | Byte count of the segment |
| seg_chain | input | 1 | 1 = more segments follow, 0 = final segment |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte taken this cycle |
| in_data | input | 8 | Stream byte |
| flush | input | 1 | Discard any held byte |
| residue_valid | output | 1 | A byte is held for pairing |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Packed word, earlier byte in the low lane |
| out_single | output | 1 | Only the low lane carries data |

## Verification
The assertions check the local rules on every cycle:
- words hold still under backpressure;
- a padded word has an empty high lane;
- the segment and byte handshakes never overlap;
- flush empties the residue;
- a zero-count descriptor leaves the residue alone;
- the residue only appears when a byte is taken.

Lane order, pairing across segment boundaries, word counts per list and the absence of a flushed byte concern whole sequences. Only the bench's sweep over pairs of segment lengths, with and without a flush between them, can show these.

// File: rtl/obp_pkg.sv
package obp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_PAD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/obp_seg_ctrl.sv
module obp_seg_ctrl
  import obp_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_valid,
  input  logic [CNT_W-1:0] seg_count,
  input  logic             seg_chain,
  input  logic             byte_take,
  input  logic             hold_now,
  input  logic             pad_fire,
  output logic             seg_ready,
  output logic             run_st,
  output logic             pad_st
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             chain_q, chain_d;
  logic             left_en;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    chain_d = chain_q;
    left_en = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (seg_valid && (seg_count != '0)) begin
          state_d = SEQ_RUN;
          left_d  = seg_count;
          chain_d = seg_chain;
          left_en = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (byte_take) begin
          left_d  = left_q - ONE;
          left_en = 1'b1;
          if (left_q == ONE) begin
            // a final segment whose last byte finds no partner must pad
            if (!chain_q && !hold_now) state_d = SEQ_PAD;
            else                       state_d = SEQ_IDLE;
          end
        end
      end
      SEQ_PAD: begin
        if (pad_fire || !hold_now) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      left_q  <= '0;
      chain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (left_en) begin
        left_q  <= left_d;
        chain_q <= chain_d;
      end
    end
  end

  assign seg_ready = (state_q == SEQ_IDLE);
  assign run_st    = (state_q == SEQ_RUN);
  assign pad_st    = (state_q == SEQ_PAD);
endmodule

// File: rtl/obp_residue.sv
module obp_residue #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              pad_fire,
  input  logic              flush,
  output logic              have_q,
  output logic              word_load,
  output logic [WORD_W-1:0] word,
  output logic              word_single
);
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              have_d;
  logic              lo_en;
  logic              pair_fire;

  assign pair_fire = byte_take && have_q;

  always_comb begin
    have_d = have_q;
    lo_d   = lo_q;
    lo_en  = 1'b0;
    if (byte_take && !have_q) begin
      lo_d   = in_data;
      lo_en  = 1'b1;
      have_d = 1'b1;
    end else if (pair_fire || pad_fire) begin
      have_d = 1'b0;
    end
    if (flush) have_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      have_q <= have_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  always_comb begin
    word_load   = pair_fire || pad_fire;
    word_single = pad_fire;
    if (pad_fire) word = {{BYTE_W{1'b0}}, lo_q};
    else          word = {in_data, lo_q};
  end
endmodule

// File: rtl/obp_out_stage.sv
module obp_out_stage #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              single,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_single
);
  logic valid_q, valid_d;
  logic single_q;

  assign slot_free = !valid_q || out_ready;

  always_comb begin
    valid_d = valid_q;
    if (out_ready) valid_d = 1'b0;
    if (load)      valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      single_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load) single_q <= single;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lane_q <= '0;
      else if (load) lane_q <= word[g*BYTE_W +: BYTE_W];
    end
    assign out_data[g*BYTE_W +: BYTE_W] = lane_q;
  end

  assign out_valid  = valid_q;
  assign out_single = single_q;
endmodule

// File: rtl/odd_byte_packer.sv
module odd_byte_packer #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [CNT_W-1:0]  seg_count,
  input  logic              seg_chain,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              flush,
  output logic              residue_valid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_single
);
  logic              rst_meta_q, rst_sync_q;
  logic              run_st, pad_st, have_q, slot_free;
  logic              byte_take, pad_fire, word_load, word_single;
  logic [WORD_W-1:0] word;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign in_ready  = run_st && (!have_q || slot_free);
  assign byte_take = in_valid && in_ready;
  assign pad_fire  = pad_st && have_q && slot_free;

  obp_seg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .seg_valid (seg_valid),
    .seg_count (seg_count),
    .seg_chain (seg_chain),
    .byte_take (byte_take),
    .hold_now  (have_q),
    .pad_fire  (pad_fire),
    .seg_ready (seg_ready),
    .run_st    (run_st),
    .pad_st    (pad_st)
  );

  obp_residue #(.BYTE_W(BYTE_W)) u_res (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .byte_take   (byte_take),
    .in_data     (in_data),
    .pad_fire    (pad_fire),
    .flush       (flush),
    .have_q      (have_q),
    .word_load   (word_load),
    .word        (word),
    .word_single (word_single)
  );

  obp_out_stage #(.BYTE_W(BYTE_W), .LANES(2)) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .load       (word_load),
    .word       (word),
    .single     (word_single),
    .out_ready  (out_ready),
    .slot_free  (slot_free),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_single (out_single)
  );

  assign residue_valid = have_q;
endmodule

// File: rtl/odd_byte_packer_chk.sv
module odd_byte_packer_chk #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [CNT_W-1:0]  seg_count,
  input logic              seg_chain,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_data,
  input logic              flush,
  input logic              residue_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_single
);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_single)));

  // R4
  pad_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_single) |-> (out_data[WORD_W-1:BYTE_W] == '0));

  // R9
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_ready |-> !in_ready);

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !residue_valid);

  // R6
  zero_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && (seg_count == '0) && !flush) |=> (residue_valid == $past(residue_valid)));

  // R2
  res_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(residue_valid) |-> $past(in_valid && in_ready));
endmodule

bind odd_byte_packer odd_byte_packer_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_odd_byte_packer.sv
`timescale 1ns/1ps
module tb_odd_byte_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_valid = 1'b0;
  logic        seg_ready;
  logic [23:0] seg_count = '0;
  logic        seg_chain = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        flush = 1'b0;
  logic        residue_valid;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_single;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int got_total = 0;
  logic [15:0] got_data [256];
  logic        got_single [256];
  logic [7:0]  bval = 8'h11;
  logic        prev_stall = 1'b0;
  logic [15:0] prev_data = '0;
  logic        prev_single = 1'b0;

  always #2.5 clk = ~clk;

  odd_byte_packer dut (
    .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_count(seg_count), .seg_chain(seg_chain), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .flush(flush),
    .residue_valid(residue_valid), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_single(out_single)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // backpressure pattern, changed just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = ((cyc % 7) != 3) && ((cyc % 5) != 1);
  end

  // collector and R8 hold check, at falling edges
  always @(negedge clk) begin
    if (prev_stall) begin
      check("R8 valid", {31'd0, out_valid}, 32'd1);
      check("R8 data", {16'd0, out_data}, {16'd0, prev_data});
      check("R8 single", {31'd0, out_single}, {31'd0, prev_single});
    end
    prev_stall  = out_valid && !out_ready;
    prev_data   = out_data;
    prev_single = out_single;
    if (out_valid && out_ready) begin
      got_data[got_total % 256]   = out_data;
      got_single[got_total % 256] = out_single;
      got_total++;
    end
  end

  task automatic send_seg(input int cnt, input logic chain);
    seg_valid = 1'b1;
    seg_count = 24'(cnt);
    seg_chain = chain;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    in_valid = 1'b1;
    in_data  = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    while (!(seg_ready && !out_valid)) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] eb [16];
    int n, start, nw;
    logic res_before;
    logic [7:0] lo, hi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 residue", {31'd0, residue_valid}, 32'd0);
    check("R10 seg_ready", {31'd0, seg_ready}, 32'd1);
    check("R10 in_ready", {31'd0, in_ready}, 32'd0);

    // sweep: chained a, optional flush, final b (a=5,b=5 is the 5+5 -> 5 words case)
    for (int a = 0; a <= 5; a++) begin
      for (int b = 0; b <= 5; b++) begin
        for (int f = 0; f <= 1; f++) begin
          n = 0;
          start = got_total;
          send_seg(a, 1'b1);
          for (int i = 0; i < a; i++) begin
            eb[n] = bval; n++;
            send_byte(bval);
            bval = bval + 8'h1d;
          end
          wait_quiet();
          // R2 odd chained tail is held, not sent
          check("R2 residue", {31'd0, residue_valid}, 32'(a % 2));
          check("R2 words", 32'(got_total - start), 32'(a / 2));
          // R9 no byte intake between segments
          check("R9 in_ready", {31'd0, in_ready}, 32'd0);
          if (f == 1) begin
            flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
            check("R7 flush", {31'd0, residue_valid}, 32'd0);
            if (a % 2 == 1) n--;
          end
          res_before = residue_valid;
          send_seg(b, 1'b0);
          for (int i = 0; i < b; i++) begin
            eb[n] = bval; n++;
            send_byte(bval);
            bval = bval + 8'h1d;
          end
          wait_quiet();
          if (b == 0)
            check("R6 zero seg", {31'd0, residue_valid}, {31'd0, res_before});
          nw = (b > 0) ? (n + 1) / 2 : n / 2;
          check("R5 count", 32'(got_total - start), 32'(nw));
          for (int w = 0; w < nw; w++) begin
            lo = eb[2*w];
            hi = (2*w + 1 < n) ? eb[2*w+1] : 8'h00;
            // R1 lane order, R3 pairing across segments, R7 flushed byte absent
            check("R1/R3 word", {16'd0, got_data[(start + w) % 256]}, {16'd0, hi, lo});
            check("R4 single", {31'd0, got_single[(start + w) % 256]},
                  {31'd0, (b > 0) && (n % 2 == 1) && (w == nw - 1)});
          end
          if (residue_valid) begin
            flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule